// File: doc/BRIEF.md
# Dual-Channel GPIO Interrupt Controller

A sixteen-pin general-purpose I/O port with two separately masked interrupt outputs. Software programs it over a simple synchronous register bus. There is one write strobe. A write takes effect at the clock edge on which `we_i` is high. A read is combinational from `addr_i`.

Each pin has the following controls:
- a direction bit;
- an input-buffer enable;
- an edge/level select;
- a polarity bit.

Input pins pass through a two-flop synchronizer before any sensing. A pin driven as an output with its input buffer enabled loops its own driven value back into the sensing logic, so software writes can raise interrupts. Edge events stay latched until software acknowledges them with a write-1-to-clear. Each channel ORs the pins enabled in its own mask and registers the result.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, both interrupt outputs are low and no pin is driven as an output.
- R2: The register addresses are:

  | Address | Register |
  |---|---|
  | 0 | port value |
  | 1 | set |
  | 2 | clear |
  | 3 | toggle |
  | 4 | direction (1 = output) |
  | 5 | input enable |
  | 6 | sense (1 = edge, 0 = level) |
  | 7 | polarity (1 = falling / active-low) |
  | 8 | mask A |
  | 9 | mask B |

  Other addresses read 0 and ignore writes. Reads of addresses 0 to 3 return the port value. For each bit of the port value:
  - an output pin shows its stored drive value;
  - an edge-mode input shows its latched event flag;
  - a level-mode input shows its synchronized pin when its input enable is 1, and 0 otherwise.
- R3: A write to set ORs the written 1 bits into the stored drive value. Clear ANDs them out, and toggle inverts them. Bits written as 0 are left unchanged. A write to address 0 loads the stored drive value directly.
- R4: `pin_o` carries the stored drive value and `pin_oe_o` carries the direction register.
- R5: A write to one channel's mask register leaves the other channel's mask unchanged.
- R6: Each interrupt output is the OR, over pins whose mask bit is 1, of that pin's interrupt condition. It is registered, so it changes one clock after the condition does. A pin may be enabled in both masks, in which case both outputs rise together.
- R7: In edge mode a pin's flag is set when its sensed value rises (polarity 0) or falls (polarity 1). The flag then stays set, even after the pin returns, until a clear write has a 1 in that bit. An input pin's change raises the interrupt four clocks after the pin changes, the first two of those clocks being the synchronizer delay.
- R8: If a clear write to a pin and a new edge on that pin fall in the same cycle, the flag stays set.
- R9: In level mode a pin's condition is its synchronized value with polarity 0 and its inverse with polarity 1. Nothing is latched, and a clear write has no effect on the condition. An input change reaches the interrupt output three clocks later.
- R10: An output pin whose input enable is 1 senses its own drive value. A set/toggle/value write raises an edge interrupt two clocks later, or a level interrupt one clock later. With input enable at 0 the pin never raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| pin_i | input | 16 | Pad input values |
| pin_o | output | 16 | Drive values to pads |
| pin_oe_o | output | 16 | Output enables to pads |
| irq_a_o | output | 1 | Interrupt channel A |
| irq_b_o | output | 1 | Interrupt channel B |

## Verification
The bench targets the following corner cases:
- **Clear and loopback edge in the same cycle.** It issues a clear back to back with a loopback set. A design that let the clear win would drop an edge that has not been serviced.
- **Latching after the pin returns.** It toggles a pin back before clearing. A level-style design would drop the interrupt early.
- **Edge-mode timing.** It samples the cycle before each expected assertion. A design missing a synchronizer stage, or with an unregistered output, would assert a cycle early.
- **Loopback gating.** A loopback pin with its input buffer off must stay silent.
- **Mask independence.** Writing one mask must not disturb the other; a shared mask decode would show up in the readback.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_VAL    = 4'd0,
    REG_SET    = 4'd1,
    REG_CLR    = 4'd2,
    REG_TGL    = 4'd3,
    REG_DIR    = 4'd4,
    REG_INEN   = 4'd5,
    REG_SENSE  = 4'd6,
    REG_POL    = 4'd7,
    REG_MASK_A = 4'd8,
    REG_MASK_B = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NPINS-1:0]    wdata_i,
  input  logic [NPINS-1:0]    pin_sync_i,
  output logic [NPINS-1:0]    drive_o,
  output logic [NPINS-1:0]    dir_o,
  output logic [NPINS-1:0]    cond_o,
  output logic [NPINS-1:0]    rdata_o
);
  logic [NPINS-1:0] drv_q, dir_q, inen_q, sense_q, pol_q, flag_q, act_q;
  logic [NPINS-1:0] sensed, act, edge_ev, clr_hit, port_val;
  logic wr_val, wr_set, wr_clr, wr_tgl;

  assign wr_val = we_i && (addr_i == REG_VAL);
  assign wr_set = we_i && (addr_i == REG_SET);
  assign wr_clr = we_i && (addr_i == REG_CLR);
  assign wr_tgl = we_i && (addr_i == REG_TGL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      inen_q  <= '0;
      sense_q <= '0;
      pol_q   <= '0;
    end else if (we_i) begin
      if (addr_i == REG_DIR)   dir_q   <= wdata_i;
      if (addr_i == REG_INEN)  inen_q  <= wdata_i;
      if (addr_i == REG_SENSE) sense_q <= wdata_i;
      if (addr_i == REG_POL)   pol_q   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     drv_q <= '0;
    else if (wr_val) drv_q <= wdata_i;
    else if (wr_set) drv_q <= drv_q | wdata_i;
    else if (wr_clr) drv_q <= drv_q & ~wdata_i;
    else if (wr_tgl) drv_q <= drv_q ^ wdata_i;
  end

  // outputs loop back their own drive value
  assign sensed  = (dir_q & drv_q) | (~dir_q & pin_sync_i);
  assign act     = inen_q & (sensed ^ pol_q);
  assign edge_ev = act & ~act_q & sense_q;
  assign clr_hit = wr_clr ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      flag_q <= '0;
    end else begin
      act_q  <= act;
      flag_q <= (flag_q & ~clr_hit) | edge_ev;  // new edge beats clear
    end
  end

  assign cond_o   = (sense_q & flag_q) | (~sense_q & act);
  assign port_val = (dir_q & drv_q)
                  | (~dir_q & sense_q & flag_q)
                  | (~dir_q & ~sense_q & inen_q & pin_sync_i);

  always_comb begin
    unique case (addr_i)
      REG_VAL, REG_SET, REG_CLR, REG_TGL: rdata_o = port_val;
      REG_DIR:   rdata_o = dir_q;
      REG_INEN:  rdata_o = inen_q;
      REG_SENSE: rdata_o = sense_q;
      REG_POL:   rdata_o = pol_q;
      default:   rdata_o = '0;
    endcase
  end

  assign drive_o = drv_q;
  assign dir_o   = dir_q;

  // R8
  flag_edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & $past(edge_ev)) == $past(edge_ev));

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q & $past(clr_hit & ~edge_ev)) == '0);

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_q) & ~$past(clr_hit) & ~flag_q) == '0);

  // R3
  set_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_set) |-> ((drv_q ^ $past(drv_q)) & ~$past(wdata_i)) == '0);
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] cond_i,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);
  logic [NPINS-1:0] mask_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      irq_q <= |(mask_q & cond_i);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R6
  mask_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_q) == '0) |-> !irq_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);
  localparam int unsigned NCH = 2;

  logic [NPINS-1:0] pin_sync, cond, regs_rdata;
  logic [NPINS-1:0] mask [NCH];
  logic [NCH-1:0]   irq;

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_port_regs #(.NPINS(NPINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .drive_o   (pin_o),
    .dir_o     (pin_oe_o),
    .cond_o    (cond),
    .rdata_o   (regs_rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic mask_we;
    assign mask_we = we_i && (addr_i == ADDR_W'(int'(REG_MASK_A) + g));

    gpio_irq_chan #(.NPINS(NPINS)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mask_we_i(mask_we),
      .wdata_i  (wdata_i),
      .cond_i   (cond),
      .mask_o   (mask[g]),
      .irq_o    (irq[g])
    );
  end

  always_comb begin
    if (addr_i == REG_MASK_A)      rdata_o = mask[0];
    else if (addr_i == REG_MASK_B) rdata_o = mask[1];
    else                           rdata_o = regs_rdata;
  end

  assign irq_a_o = irq[0];
  assign irq_b_o = irq[1];

  // R5
  mask_a_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == REG_MASK_A) |-> $stable(mask[1]));

  // R5
  mask_b_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == REG_MASK_B) |-> $stable(mask[0]));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int N = 16;
  localparam int SEL_RD = 0, SEL_IA = 1, SEL_IB = 2, SEL_PO = 3, SEL_OE = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   addr = '0;
  logic         we = 1'b0;
  logic [N-1:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic         irq_a, irq_b;
  int           cyc = 0, checks = 0, errors = 0;

  typedef struct {
    int          due;
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_irq_ctrl #(.NPINS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  function automatic logic [15:0] pick(int sel);
    case (sel)
      SEL_RD:  return rdata;
      SEL_IA:  return {15'd0, irq_a};
      SEL_IB:  return {15'd0, irq_b};
      SEL_PO:  return pin_out;
      default: return pin_oe;
    endcase
  endfunction

  // monitor: pops due items and compares
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [15:0] act;
        act = pick(sb[i].sel);
        checks++;
        if (act !== sb[i].exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", sb[i].req, sb[i].sel, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int off, int sel, logic [15:0] exp, string req);
    item_t it;
    it.due = cyc + off; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [N-1:0] exp, string req);
    addr = a;
    expect_at(0, SEL_RD, exp, req);
    idle(1);
  endtask

  task automatic do_reset();
    we = 1'b0;
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    idle(2);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 10; a++) rd_chk(4'(a), '0, "R1 reg reset");
    expect_at(0, SEL_IA, 0, "R1 irq_a reset");
    expect_at(0, SEL_IB, 0, "R1 irq_b reset");
    expect_at(0, SEL_OE, 0, "R1 oe reset");
    idle(1);

    // R3/R4 set, clear, toggle
    wr(4, 16'hFFFF);
    wr(0, 16'h00F0);
    rd_chk(0, 16'h00F0, "R3 load value");
    wr(1, 16'h0003);
    rd_chk(1, 16'h00F3, "R3 set");
    wr(2, 16'h0030);
    rd_chk(2, 16'h00C3, "R3 clear");
    wr(3, 16'h0101);
    rd_chk(3, 16'h01C2, "R3 toggle");
    expect_at(0, SEL_PO, 16'h01C2, "R4 pin_o");
    expect_at(0, SEL_OE, 16'hFFFF, "R4 pin_oe");
    idle(1);

    // R2 mixed readback
    pin_in = 16'hA5FF;
    wr(4, 16'h00FF);
    wr(5, 16'hFF00);
    idle(3);
    rd_chk(0, 16'hA5C2, "R2 mixed value read");
    rd_chk(4'hF, 16'h0000, "R2 unmapped read");

    // R5 independent masks
    wr(8, 16'h000F);
    rd_chk(9, 16'h0000, "R5 mask B untouched");
    wr(9, 16'h00F0);
    rd_chk(8, 16'h000F, "R5 mask A untouched");
    rd_chk(9, 16'h00F0, "R5 mask B written");
    expect_at(1, SEL_IA, 0, "R6 no cond no irq");

    // R7/R10 loopback edge latch
    pin_in = '0;
    do_reset();
    wr(4, 16'h0001); wr(5, 16'h0001); wr(6, 16'h0001); wr(8, 16'h0001);
    wr(1, 16'h0001);
    expect_at(1, SEL_IA, 0, "R10 edge loopback not early");
    expect_at(2, SEL_IA, 1, "R10 edge loopback irq");
    expect_at(2, SEL_IB, 0, "R6 unmasked channel quiet");
    idle(3);
    wr(3, 16'h0001);
    idle(3);
    expect_at(0, SEL_IA, 1, "R7 latched after return");
    idle(1);
    wr(2, 16'h0001);
    expect_at(1, SEL_IA, 0, "R7 clear drops irq");
    idle(2);

    // R8 edge wins over clear
    wr(1, 16'h0001);
    wr(2, 16'h0001);
    expect_at(1, SEL_IA, 1, "R8 edge wins");
    idle(3);
    expect_at(0, SEL_IA, 1, "R8 still latched");
    idle(1);
    wr(2, 16'h0001);
    expect_at(1, SEL_IA, 0, "R8 later clear");
    idle(2);

    // R7 falling edge on input pin 4, rising on pin 5
    pin_in = 16'h0010;
    do_reset();
    wr(5, 16'h0030); wr(6, 16'h0030); wr(7, 16'h0010);
    wr(9, 16'h0010); wr(8, 16'h0020);
    idle(2);
    pin_in = 16'h0000;
    expect_at(3, SEL_IB, 0, "R7 sync latency");
    expect_at(4, SEL_IB, 1, "R7 falling edge irq");
    expect_at(4, SEL_IA, 0, "R7 falling on rising pin");
    idle(5);
    rd_chk(0, 16'h0010, "R7 flag readable");
    pin_in = 16'h0010;
    idle(4);
    expect_at(0, SEL_IB, 1, "R7 held after pin returns");
    idle(1);
    wr(2, 16'h0010);
    expect_at(1, SEL_IB, 0, "R7 input clear");
    idle(2);
    pin_in = 16'h0030;
    expect_at(4, SEL_IA, 1, "R7 rising edge irq");
    expect_at(4, SEL_IB, 0, "R7 rising on falling pin");
    idle(6);

    // R9 level active-low
    pin_in = 16'h0100;
    do_reset();
    wr(5, 16'h0100); wr(7, 16'h0100); wr(8, 16'h0100);
    idle(2);
    pin_in = 16'h0000;
    expect_at(2, SEL_IA, 0, "R9 level latency");
    expect_at(3, SEL_IA, 1, "R9 active-low level irq");
    expect_at(3, SEL_IB, 0, "R9 channel B quiet");
    idle(4);
    wr(2, 16'h0100);
    expect_at(1, SEL_IA, 1, "R9 clear has no effect");
    idle(2);
    pin_in = 16'h0100;
    expect_at(2, SEL_IA, 1, "R9 release latency");
    expect_at(3, SEL_IA, 0, "R9 level follows pin");
    idle(4);

    // R10 input enable gating, R6 both channels
    pin_in = '0;
    do_reset();
    wr(4, 16'h0006); wr(5, 16'h0004); wr(8, 16'h0006); wr(9, 16'h0004);
    wr(1, 16'h0002);
    expect_at(1, SEL_IA, 0, "R10 inen off quiet");
    expect_at(2, SEL_IA, 0, "R10 inen off quiet late");
    idle(3);
    wr(1, 16'h0004);
    expect_at(1, SEL_IA, 1, "R10 level loopback A");
    expect_at(1, SEL_IB, 1, "R6 both channels B");
    idle(2);
    wr(3, 16'h0004);
    expect_at(1, SEL_IA, 0, "R9 level drop A");
    expect_at(1, SEL_IB, 0, "R9 level drop B");
    idle(4);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard %0d items left, expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule